// File: doc/BRIEF.md
# Three-Group Prioritised Interrupt Aggregator

This block gathers sticky event flags from three sources inside a serial controller: the receive path, the transmit path and the modem-line (serial interface) monitor. Each source has its own status register, which the datapath sets with one-cycle event pulses and can clear again with its own clear pulses. Each source also has an enable register of the same width. A CPU write port writes to all six registers. On a status register, a 1 clears the flag in that position. On an enable register, the written value replaces the old contents.

A group asks for service while any flag that is both set and enabled remains. The block drives one request line per group. It also drives a combined request with a 2-bit code that names the most urgent pending group. Receive has the highest priority, then transmit, then the serial interface. Requests come straight from the stored status and enable values. A write to either register therefore shows on the request lines in the cycle after the write edge. No separate recompute step is needed.

Top module: `irq_agg3`

## Requirements
- R1: While reset is held, and after it is released, every status register and every enable register is zero. All group requests are low, `irq_any` is 0 and `irq_grp` is 2'd0.
- R2: A 1 on an event-set input sets the matching status bit at the next clock edge, whatever the enable bit holds. The bit stays set until something clears it.
- R3: A CPU write with `cpu_sel` 0 (receive), 2 (transmit) or 4 (serial interface) clears each status bit whose data bit is 1. Bits written as 0 keep their value. A status bit never rises without an event-set pulse.
- R4: Bit 0 of the receive status (data available) and bit 0 of the transmit status (data register available) cannot be changed by CPU status writes. Only an event-set pulse or a datapath clear pulse changes them. Every serial-interface status bit can be cleared by a CPU write.
- R5: If an event-set pulse arrives in the same cycle as a CPU clear or a datapath clear of the same bit, the set wins and the bit is 1 afterwards.
- R6: A CPU write with `cpu_sel` 1, 3 or 5 loads the receive, transmit or serial-interface enable register from the low bits of `cpu_wdata`. The new value takes effect at the next edge.
- R7: Each group's request equals the OR over its bits of status AND enable. It rises in the cycle after an enable write uncovers a set flag. It falls in the cycle after the last enabled flag is cleared.
- R8: `irq_any` is 1 when any group requests. `irq_grp` is 2'd1 when receive requests, otherwise 2'd2 when transmit requests, otherwise 2'd3 when the serial interface requests, and 2'd0 when nothing requests.
- R9: A CPU write with `cpu_sel` 6 or 7 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_set | input | RX_W | Receive event-set pulses, one per status bit |
| rx_hwclr | input | RX_W | Receive datapath clear pulses |
| tx_set | input | TX_W | Transmit event-set pulses |
| tx_hwclr | input | TX_W | Transmit datapath clear pulses |
| si_set | input | SI_W | Modem-line transition event-set pulses |
| si_hwclr | input | SI_W | Serial-interface datapath clear pulses |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_sel | input | 3 | Register select: 0/1 rx status/enable, 2/3 tx, 4/5 serial interface |
| cpu_wdata | input | DW | CPU write data |
| rx_status | output | RX_W | Receive status register |
| tx_status | output | TX_W | Transmit status register |
| si_status | output | SI_W | Serial-interface status register |
| rx_req | output | 1 | Receive group request |
| tx_req | output | 1 | Transmit group request |
| si_req | output | 1 | Serial-interface group request |
| irq_any | output | 1 | Combined request |
| irq_grp | output | 2 | Code of the highest pending group |

## Verification
The assertions are checked on every cycle. They cover these rules: a set pulse always leaves its bit set (R2, R5), no status bit rises without a pulse (R3), protected bits survive CPU writes (R4), enable writes load exactly (R6), and the combined code follows the priority order over the group requests (R8). Some behaviour can only be shown through the bench's scenarios against its own register model: that the request follows a late enable write, that partial clears act on only the written bits, and that unused select codes leave everything untouched. Those scenarios mix directed cases with long randomised runs.

// File: rtl/irq_agg3_pkg.sv
package irq_agg3_pkg;
  typedef enum logic [2:0] {
    SEL_RX_STS = 3'd0,
    SEL_RX_EN  = 3'd1,
    SEL_TX_STS = 3'd2,
    SEL_TX_EN  = 3'd3,
    SEL_SI_STS = 3'd4,
    SEL_SI_EN  = 3'd5
  } reg_sel_e;

  localparam logic [1:0] GRP_NONE = 2'd0;
  localparam logic [1:0] GRP_RX   = 2'd1;
  localparam logic [1:0] GRP_TX   = 2'd2;
  localparam logic [1:0] GRP_SI   = 2'd3;
endpackage

// File: rtl/irq_grp_regs.sv
module irq_grp_regs #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RO_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sts_wr,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ev_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] status,
  output logic         req
);
  logic [W-1:0] sts_q, sts_d, en_q, en_d, wr_clr;
  logic         sts_ce;

  // next state
  always_comb begin
    wr_clr = sts_wr ? (wdata & ~RO_MASK) : '0;
    sts_d  = (sts_q & ~wr_clr & ~hw_clr) | ev_set;
    en_d   = wdata;
    sts_ce = sts_wr | (|ev_set) | (|hw_clr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      if (sts_ce) sts_q <= sts_d;
      if (en_wr)  en_q  <= en_d;
    end
  end

  assign status = sts_q;
  assign req    = |(sts_q & en_q);

  // R2 and R5: a set pulse always leaves its bit set
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_set) |=> ((sts_q & $past(ev_set)) == $past(ev_set)));

  // R3: no bit rises without a set pulse
  a_r3_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr || !sts_wr) |=> ((sts_q & ~$past(sts_q) & ~$past(ev_set)) == '0));

  // R4: protected bits survive CPU status writes
  a_r4_ro_protected: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> (((sts_q ^ $past(sts_q)) & RO_MASK & ~$past(ev_set) & ~$past(hw_clr)) == '0));

  // R6: enable write loads the data
  a_r6_en_load: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(wdata)));
endmodule

// File: rtl/irq_prio3.sv
module irq_prio3
  import irq_agg3_pkg::*;
(
  input  logic [2:0] req,
  output logic       any,
  output logic [1:0] grp
);
  always_comb begin
    any = |req;
    if (req[0])      grp = GRP_RX;
    else if (req[1]) grp = GRP_TX;
    else if (req[2]) grp = GRP_SI;
    else             grp = GRP_NONE;
  end
endmodule

// File: rtl/irq_agg3.sv
module irq_agg3
  import irq_agg3_pkg::*;
#(
  parameter int              RX_W  = 6,
  parameter int              TX_W  = 4,
  parameter int              SI_W  = 3,
  parameter int              DW    = 8,
  parameter logic [RX_W-1:0] RX_RO = 6'b000001,
  parameter logic [TX_W-1:0] TX_RO = 4'b0001,
  parameter logic [SI_W-1:0] SI_RO = 3'b000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RX_W-1:0] rx_set,
  input  logic [RX_W-1:0] rx_hwclr,
  input  logic [TX_W-1:0] tx_set,
  input  logic [TX_W-1:0] tx_hwclr,
  input  logic [SI_W-1:0] si_set,
  input  logic [SI_W-1:0] si_hwclr,
  input  logic            cpu_wr,
  input  logic [2:0]      cpu_sel,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [RX_W-1:0] rx_status,
  output logic [TX_W-1:0] tx_status,
  output logic [SI_W-1:0] si_status,
  output logic            rx_req,
  output logic            tx_req,
  output logic            si_req,
  output logic            irq_any,
  output logic [1:0]      irq_grp
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] rst_sync_q;
  logic             rst_int_n;
  logic [2:0]       grp_req;
  logic [5:0]       wr_dec;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[NSYNC-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[NSYNC-1];

  // write decode, one strobe per register
  always_comb begin
    wr_dec = '0;
    if (cpu_wr) begin
      for (int i = 0; i < 6; i++) wr_dec[i] = (cpu_sel == 3'(i));
    end
  end

  irq_grp_regs #(.W(RX_W), .RO_MASK(RX_RO)) u_rx (
    .clk(clk), .rst_n(rst_int_n),
    .sts_wr(wr_dec[SEL_RX_STS]), .en_wr(wr_dec[SEL_RX_EN]),
    .wdata(cpu_wdata[RX_W-1:0]), .ev_set(rx_set), .hw_clr(rx_hwclr),
    .status(rx_status), .req(grp_req[0]));

  irq_grp_regs #(.W(TX_W), .RO_MASK(TX_RO)) u_tx (
    .clk(clk), .rst_n(rst_int_n),
    .sts_wr(wr_dec[SEL_TX_STS]), .en_wr(wr_dec[SEL_TX_EN]),
    .wdata(cpu_wdata[TX_W-1:0]), .ev_set(tx_set), .hw_clr(tx_hwclr),
    .status(tx_status), .req(grp_req[1]));

  irq_grp_regs #(.W(SI_W), .RO_MASK(SI_RO)) u_si (
    .clk(clk), .rst_n(rst_int_n),
    .sts_wr(wr_dec[SEL_SI_STS]), .en_wr(wr_dec[SEL_SI_EN]),
    .wdata(cpu_wdata[SI_W-1:0]), .ev_set(si_set), .hw_clr(si_hwclr),
    .status(si_status), .req(grp_req[2]));

  irq_prio3 u_prio (.req(grp_req), .any(irq_any), .grp(irq_grp));

  assign rx_req = grp_req[0];
  assign tx_req = grp_req[1];
  assign si_req = grp_req[2];

  // R8: the code follows fixed priority over the group requests
  a_r8_rx_wins: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_req |-> (irq_grp == GRP_RX));
  a_r8_tx_second: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_req && !rx_req) |-> (irq_grp == GRP_TX));
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(rx_req || tx_req || si_req) |-> (!irq_any && irq_grp == GRP_NONE));
endmodule

// File: tb/irq_agg3_bench.sv
module irq_agg3_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RX_W = 6;
  localparam int TX_W = 4;
  localparam int SI_W = 3;
  localparam logic [7:0] RX_RO = 8'h01;
  localparam logic [7:0] TX_RO = 8'h01;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [RX_W-1:0] rx_set, rx_hwclr;
  logic [TX_W-1:0] tx_set, tx_hwclr;
  logic [SI_W-1:0] si_set, si_hwclr;
  logic            cpu_wr;
  logic [2:0]      cpu_sel;
  logic [7:0]      cpu_wdata;
  logic [RX_W-1:0] rx_status;
  logic [TX_W-1:0] tx_status;
  logic [SI_W-1:0] si_status;
  logic            rx_req, tx_req, si_req, irq_any;
  logic [1:0]      irq_grp;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_rx, m_tx, m_si, e_rx, e_tx, e_si;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_agg3 u_irq_agg3 (
    .clk(clk), .rst_n(rst_n),
    .rx_set(rx_set), .rx_hwclr(rx_hwclr), .tx_set(tx_set), .tx_hwclr(tx_hwclr),
    .si_set(si_set), .si_hwclr(si_hwclr),
    .cpu_wr(cpu_wr), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .rx_status(rx_status), .tx_status(tx_status), .si_status(si_status),
    .rx_req(rx_req), .tx_req(tx_req), .si_req(si_req),
    .irq_any(irq_any), .irq_grp(irq_grp));

  function automatic logic [7:0] nxt(logic [7:0] cur, logic [7:0] st, logic [7:0] hc,
                                     logic wr, logic [7:0] wd, logic [7:0] ro);
    logic [7:0] c;
    c = wr ? (wd & ~ro) : 8'h00;
    return (cur & ~c & ~hc) | st;
  endfunction

  function automatic logic [1:0] exp_grp(logic a, logic b, logic c);
    if (a) return 2'd1;
    if (b) return 2'd2;
    if (c) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_set = '0; rx_hwclr = '0; tx_set = '0; tx_hwclr = '0;
    si_set = '0; si_hwclr = '0; cpu_wr = 1'b0; cpu_sel = 3'd0; cpu_wdata = 8'h00;
  endtask

  // apply current inputs for one edge, update model, return at negedge
  task automatic tick();
    logic [7:0] wm;
    wm = cpu_wr ? {5'd0, cpu_sel} : 8'hFF;
    m_rx = nxt(m_rx, 8'(rx_set), 8'(rx_hwclr), wm == 8'd0, cpu_wdata & 8'h3F, RX_RO);
    m_tx = nxt(m_tx, 8'(tx_set), 8'(tx_hwclr), wm == 8'd2, cpu_wdata & 8'h0F, TX_RO);
    m_si = nxt(m_si, 8'(si_set), 8'(si_hwclr), wm == 8'd4, cpu_wdata & 8'h07, 8'h00);
    if (wm == 8'd1) e_rx = cpu_wdata & 8'h3F;
    if (wm == 8'd3) e_tx = cpu_wdata & 8'h0F;
    if (wm == 8'd5) e_si = cpu_wdata & 8'h07;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic cpu_write(logic [2:0] sel, logic [7:0] d);
    cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
    tick();
  endtask

  task automatic check_all(string tag);
    logic ra, ta, sa;
    ra = |(m_rx & e_rx); ta = |(m_tx & e_tx); sa = |(m_si & e_si);
    chk({tag, " rx_status"}, 8'(rx_status), m_rx);
    chk({tag, " tx_status"}, 8'(tx_status), m_tx);
    chk({tag, " si_status"}, 8'(si_status), m_si);
    chk({tag, " reqs"}, {5'd0, si_req, tx_req, rx_req}, {5'd0, sa, ta, ra});
    chk({tag, " irq_any"}, 8'(irq_any), 8'(ra | ta | sa));
    chk({tag, " irq_grp"}, 8'(irq_grp), 8'(exp_grp(ra, ta, sa)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    m_rx = 0; m_tx = 0; m_si = 0; e_rx = 0; e_tx = 0; e_si = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after reset");

    // R2: set while disabled
    tx_set = 4'b0100; tick();
    check_all("R2 set disabled");
    chk("R2 tx_req low while disabled", 8'(tx_req), 8'h00);

    // R7: enabling a set flag raises the request
    cpu_write(3'd3, 8'h04);
    check_all("R7 enable raises");
    chk("R7 tx_req high", 8'(tx_req), 8'h01);

    // R3: zero write keeps, one write clears
    cpu_write(3'd2, 8'h00);
    check_all("R3 zero write");
    cpu_write(3'd2, 8'h04);
    check_all("R3 clear bit");
    chk("R7 tx_req drops", 8'(tx_req), 8'h00);

    // R4: protected bit
    tx_set = 4'b0001; rx_set = 6'b000011; tick();
    cpu_write(3'd2, 8'hFF);
    cpu_write(3'd0, 8'hFF);
    check_all("R4 ro survives");
    chk("R4 tx bit0", 8'(tx_status), 8'h01);
    chk("R4 rx bit0", 8'(rx_status), 8'h01);
    tx_hwclr = 4'b0001; rx_hwclr = 6'b000001; tick();
    check_all("R4 hw clear");

    // R5: set wins over clears
    si_set = 3'b010; cpu_wr = 1'b1; cpu_sel = 3'd4; cpu_wdata = 8'h02; tick();
    check_all("R5 set vs cpu clear");
    chk("R5 si bit1", 8'(si_status), 8'h02);
    tx_set = 4'b1000; tx_hwclr = 4'b1000; tick();
    check_all("R5 set vs hw clear");

    // R6, R8: priority walk
    cpu_write(3'd5, 8'h07);
    cpu_write(3'd3, 8'h0F);
    rx_set = 6'b001000; tick();
    cpu_write(3'd1, 8'h08);
    check_all("R6 R8 rx top");
    chk("R8 grp rx", 8'(irq_grp), 8'h01);
    cpu_write(3'd0, 8'h08);
    check_all("R8 tx next");
    chk("R8 grp tx", 8'(irq_grp), 8'h02);
    cpu_write(3'd2, 8'h08);
    check_all("R8 si last");
    chk("R8 grp si", 8'(irq_grp), 8'h03);

    // R9: unused selects
    cpu_write(3'd6, 8'hFF);
    check_all("R9 sel6");
    cpu_write(3'd7, 8'hFF);
    check_all("R9 sel7");

    // randomised run
    for (int i = 0; i < 2000; i++) begin
      if (($urandom % 4) == 0) rx_set = RX_W'($urandom);
      if (($urandom % 4) == 0) tx_set = TX_W'($urandom);
      if (($urandom % 4) == 0) si_set = SI_W'($urandom);
      if (($urandom % 6) == 0) rx_hwclr = RX_W'($urandom);
      if (($urandom % 6) == 0) tx_hwclr = TX_W'($urandom);
      if (($urandom % 6) == 0) si_hwclr = SI_W'($urandom);
      if (($urandom % 2) == 0) begin
        cpu_wr = 1'b1; cpu_sel = 3'($urandom); cpu_wdata = 8'($urandom);
      end
      tick();
      check_all("R2 R3 R5 R7 R8 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule